// File: doc/BRIEF.md
# ADC Dual-Converter Scan Sequencer

This block runs the scan of a sixteen-entry sample list across two analog converters, called A and B. It decides which list entry each converter handles next, drives a request/done handshake to each converter, and reports when a scan is over. Analog conversion and result handling sit outside the block.

A scan is launched by a one-cycle start pulse or by an external sync pulse while sync is enabled. A trigger that arrives while a scan is in progress is dropped. In sequential mode converter A alone walks the list in ascending order. In parallel mode the list is cut into groups of four entries and the groups are dealt out alternately to A and B, so both converters work at once. A joint-stop option picks whether a disabled entry met by either converter ends the whole scan, or only that converter's share of it. A stop level per converter aborts the scan that converter is running and blocks new triggers for as long as it is held.

The slot-enable mask is copied at launch, so edits made during a scan only apply to the next one. Mode, joint-stop and sync-enable are configuration inputs that are held steady while a scan runs.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset both converters are idle: `req_a`, `req_b`, `cmp_a` and `cmp_b` are 0, `slot_a` is 0, and `slot_b` is 4 when `mode_par`=1.
- R2: With `mode_par`=0, converter A requests slots 0, 1, 2 … in ascending order, one per accepted done, and `req_b` stays 0.
- R3: A sequential scan that reaches a disabled slot does not request that slot. `cmp_a` pulses for exactly one cycle on the cycle after the disabled slot is reached. If slot 0 is disabled, the scan ends without any request. If no slot is disabled, `cmp_a` pulses on the cycle after the done for slot 15.
- R4: With `mode_par`=1, converter A handles slots 0–3 and then 8–11, and converter B handles slots 4–7 and then 12–15. Both converters run at the same time and advance in step with their own done inputs. Slot bit 2 is 0 on A and 1 on B.
- R5: With `mode_par`=1 and `simult`=1, `start_a`/`sync_a` launch both converters. The scan ends for both as soon as either converter reaches a disabled slot, or once both have finished their last slot. `cmp_a` and `cmp_b` then pulse in the same cycle.
- R6: With `mode_par`=1 and `simult`=0, converter B is launched by `start_b`/`sync_b`. Each converter ends on its own disabled slot or its own last slot, and pulses only its own complete output.
- R7: A trigger that arrives while that converter's scan is active is ignored, and the scan carries on from where it was. A sync pulse has no effect when `sync_en`=0.
- R8: Raising `stop_a` aborts A's scan. On the next cycle `req_a` is 0, and no complete pulse is given for the aborted scan. Start and sync triggers are ignored while `stop_a` is high and are not remembered after it falls.
- R9: `stop_b` acts on converter B only with `mode_par`=1 and `simult`=0. In that mode it aborts B and blocks B's triggers. In any other mode it has no effect.
- R10: A start pulse and a sync pulse in the same cycle produce one scan and one complete pulse.
- R11: The slot-enable mask is captured when a scan launches. Changes to `slot_en` during the scan do not alter that scan.
- R12: A request stays high on the same slot until its done input is seen high at a clock edge. The slot index then advances on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_par | input | 1 | 1 = parallel mode, 0 = sequential mode |
| simult | input | 1 | 1 = joint stop of both converters in parallel mode |
| sync_en | input | 1 | Enables the sync inputs as triggers |
| start_a | input | 1 | One-cycle start pulse, converter A (or both when joint) |
| start_b | input | 1 | One-cycle start pulse, converter B (independent parallel only) |
| sync_a | input | 1 | External sync pulse for A |
| sync_b | input | 1 | External sync pulse for B |
| stop_a | input | 1 | Stop level for A (both converters outside independent parallel) |
| stop_b | input | 1 | Stop level for B, independent parallel only |
| slot_en | input | NUM_SLOTS | Per-slot enable mask, bit n = slot n |
| done_a | input | 1 | Conversion done from converter A |
| done_b | input | 1 | Conversion done from converter B |
| req_a | output | 1 | Conversion request to converter A |
| req_b | output | 1 | Conversion request to converter B |
| slot_a | output | log2(NUM_SLOTS) | Current slot of converter A |
| slot_b | output | log2(NUM_SLOTS) | Current slot of converter B |
| cmp_a | output | 1 | One-cycle scan-complete pulse, converter A |
| cmp_b | output | 1 | One-cycle scan-complete pulse, converter B |

## Verification
Two things can land in the same cycle: a start-bit pulse and an external sync pulse. They may arrive together while idle, or a trigger may arrive while a scan is already running or while stop is held. The bench raises start and sync together on one negative edge, then counts complete pulses over a window long enough for two scans, and passes only if it sees exactly one. It also pulses sync during a running scan and checks that the slot index keeps advancing instead of falling back to 0. Finally, it sends triggers while stop is held and checks that none of them launches a scan after stop is released.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

   // Slot number handled by a lane at list position pos in parallel mode.
   // Groups of grp slots are dealt out alternately to lane 0 and lane 1.
   function automatic int unsigned par_slot(input int unsigned pos,
                                            input int unsigned lane,
                                            input int unsigned grp);
      return (pos / grp) * 2 * grp + lane * grp + (pos % grp);
   endfunction

endpackage

// File: rtl/adc_scan_trig.sv
module adc_scan_trig (
   input  logic start,
   input  logic sync,
   input  logic sync_en,
   input  logic stop,
   input  logic busy,
   output logic fire
);

   // Start and sync merge into one launch; stop and an active scan block both.
   assign fire = (start | (sync & sync_en)) & ~stop & ~busy;

endmodule

// File: rtl/adc_scan_lane.sv
module adc_scan_lane #(
   parameter  int unsigned NUM_SLOTS = 16,
   parameter  int unsigned GROUP     = 4,
   parameter  int unsigned LANE      = 0,
   localparam int unsigned IDX_W     = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 par,
   input  logic                 launch,
   input  logic                 kill,
   input  logic                 solo,
   input  logic                 joint_end,
   input  logic [NUM_SLOTS-1:0] en_mask,
   input  logic                 done,
   output logic                 req,
   output logic [IDX_W-1:0]     slot,
   output logic                 active,
   output logic                 finished,
   output logic                 hit_off,
   output logic                 last_done,
   output logic                 cmp
);

   localparam int unsigned HALF = NUM_SLOTS / 2;

   logic [IDX_W-1:0]     pos_q;
   logic [NUM_SLOTS-1:0] mask_q;
   logic                 act_q;
   logic                 fin_q;
   logic                 cmp_q;
   logic [IDX_W-1:0]     last_pos;
   logic [IDX_W-1:0]     slot_w;
   logic                 step;

   always_comb begin
      last_pos  = par ? IDX_W'(HALF - 1) : IDX_W'(NUM_SLOTS - 1);
      slot_w    = par ? IDX_W'(adc_scan_pkg::par_slot(int'(pos_q), LANE, GROUP))
                      : pos_q;
      req       = act_q & mask_q[slot_w];
      hit_off   = act_q & ~mask_q[slot_w];
      step      = req & done;
      last_done = step & (pos_q == last_pos);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= '0;
         mask_q <= '0;
         act_q  <= 1'b0;
         fin_q  <= 1'b0;
         cmp_q  <= 1'b0;
      end else begin
         cmp_q <= 1'b0;
         if (kill) begin
            act_q <= 1'b0;
            fin_q <= 1'b0;
            pos_q <= '0;
         end else if (launch) begin
            act_q  <= 1'b1;
            fin_q  <= 1'b0;
            pos_q  <= '0;
            mask_q <= en_mask;
         end else if (solo) begin
            fin_q <= 1'b0;
            if (hit_off | last_done) begin
               act_q <= 1'b0;
               pos_q <= '0;
               cmp_q <= 1'b1;
            end else if (step) begin
               pos_q <= pos_q + IDX_W'(1);
            end
         end else begin
            if (joint_end) begin
               act_q <= 1'b0;
               fin_q <= 1'b0;
               pos_q <= '0;
               cmp_q <= 1'b1;
            end else if (last_done) begin
               act_q <= 1'b0;
               fin_q <= 1'b1;
            end else if (step) begin
               pos_q <= pos_q + IDX_W'(1);
            end
         end
      end
   end

   assign slot     = slot_w;
   assign active   = act_q;
   assign finished = fin_q;
   assign cmp      = cmp_q;

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
   parameter  int unsigned NUM_SLOTS = 16,
   parameter  int unsigned GROUP     = 4,
   localparam int unsigned IDX_W     = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_par,
   input  logic                 simult,
   input  logic                 sync_en,
   input  logic                 start_a,
   input  logic                 start_b,
   input  logic                 sync_a,
   input  logic                 sync_b,
   input  logic                 stop_a,
   input  logic                 stop_b,
   input  logic [NUM_SLOTS-1:0] slot_en,
   input  logic                 done_a,
   input  logic                 done_b,
   output logic                 req_a,
   output logic                 req_b,
   output logic [IDX_W-1:0]     slot_a,
   output logic [IDX_W-1:0]     slot_b,
   output logic                 cmp_a,
   output logic                 cmp_b
);

   localparam int unsigned LANES = 2;

   if (GROUP == 0 || (GROUP & (GROUP - 1)) != 0) begin : g_bad_group
      $error("GROUP must be a nonzero power of two");
   end
   if (NUM_SLOTS % (2 * GROUP) != 0) begin : g_bad_slots
      $error("NUM_SLOTS must be a multiple of 2*GROUP");
   end

   logic                 joint;
   logic                 indep_b;
   logic                 joint_end;
   logic [LANES-1:0]     start_v, sync_v, stop_v, busy_v, fire_v;
   logic [LANES-1:0]     launch_v, kill_v, done_v;
   logic [LANES-1:0]     req_v, act_v, fin_v, hit_v, last_v, cmp_v;
   logic [IDX_W-1:0]     slot_v [LANES];

   always_comb begin
      joint   = mode_par & simult;
      indep_b = mode_par & ~simult;

      start_v = {start_b, start_a};
      sync_v  = {sync_b, sync_a};
      done_v  = {done_b, done_a};
      stop_v  = {(indep_b ? stop_b : stop_a), stop_a};

      busy_v[0] = act_v[0] | fin_v[0] | (joint & (act_v[1] | fin_v[1]));
      busy_v[1] = act_v[1] | fin_v[1];

      launch_v[0] = fire_v[0];
      launch_v[1] = joint ? fire_v[0] : (indep_b & fire_v[1]);

      kill_v[0] = stop_v[0];
      kill_v[1] = ~mode_par | stop_v[1];

      joint_end = joint & (hit_v[0] | hit_v[1] |
                           ((fin_v[0] | last_v[0]) & (fin_v[1] | last_v[1])));
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      adc_scan_trig u_trig (
         .start   (start_v[g]),
         .sync    (sync_v[g]),
         .sync_en (sync_en),
         .stop    (stop_v[g]),
         .busy    (busy_v[g]),
         .fire    (fire_v[g])
      );

      adc_scan_lane #(
         .NUM_SLOTS (NUM_SLOTS),
         .GROUP     (GROUP),
         .LANE      (g)
      ) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .par       (mode_par),
         .launch    (launch_v[g]),
         .kill      (kill_v[g]),
         .solo      (~joint),
         .joint_end (joint_end),
         .en_mask   (slot_en),
         .done      (done_v[g]),
         .req       (req_v[g]),
         .slot      (slot_v[g]),
         .active    (act_v[g]),
         .finished  (fin_v[g]),
         .hit_off   (hit_v[g]),
         .last_done (last_v[g]),
         .cmp       (cmp_v[g])
      );
   end

   assign req_a  = req_v[0];
   assign req_b  = req_v[1];
   assign slot_a = slot_v[0];
   assign slot_b = slot_v[1];
   assign cmp_a  = cmp_v[0];
   assign cmp_b  = cmp_v[1];

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
   parameter  int unsigned NUM_SLOTS = 16,
   parameter  int unsigned GROUP     = 4,
   localparam int unsigned IDX_W     = $clog2(NUM_SLOTS),
   localparam int unsigned GB        = $clog2(GROUP)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_par,
   input logic             simult,
   input logic             stop_a,
   input logic             done_a,
   input logic             req_a,
   input logic             req_b,
   input logic [IDX_W-1:0] slot_a,
   input logic [IDX_W-1:0] slot_b,
   input logic             cmp_a,
   input logic             cmp_b
);

   assert_b_quiet_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_par && $past(!mode_par)) |-> !req_b);

   assert_cmp_a_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_a |=> !cmp_a);

   assert_cmp_b_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_b |=> !cmp_b);

   assert_slot_split_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mode_par |-> (slot_a[GB] == 1'b0 && slot_b[GB] == 1'b1));

   assert_joint_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mode_par && simult) |-> (cmp_a == cmp_b));

   assert_stop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_a |=> (!req_a && !cmp_a));

   assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_a && !done_a && !stop_a && !mode_par) ##1 !mode_par
      |-> (req_a && $stable(slot_a)));

endmodule

bind adc_scan_seq adc_scan_seq_chk #(
   .NUM_SLOTS (NUM_SLOTS),
   .GROUP     (GROUP)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_par (mode_par),
   .simult   (simult),
   .stop_a   (stop_a),
   .done_a   (done_a),
   .req_a    (req_a),
   .req_b    (req_b),
   .slot_a   (slot_a),
   .slot_b   (slot_b),
   .cmp_a    (cmp_a),
   .cmp_b    (cmp_b)
);

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_par = 1'b1, simult = 1'b1, sync_en = 1'b0;
   logic        start_a = 1'b0, start_b = 1'b0, sync_a = 1'b0, sync_b = 1'b0;
   logic        stop_a = 1'b0, stop_b = 1'b0;
   logic [15:0] slot_en = '1;
   logic        done_a = 1'b0, done_b = 1'b0;
   logic        req_a, req_b, cmp_a, cmp_b;
   logic [3:0]  slot_a, slot_b;

   int total = 0;
   int bad   = 0;
   bit ended = 0;

   always #2.5 clk = ~clk;

   adc_scan_seq uut (
      .clk(clk), .rst_n(rst_n), .mode_par(mode_par), .simult(simult),
      .sync_en(sync_en), .start_a(start_a), .start_b(start_b),
      .sync_a(sync_a), .sync_b(sync_b), .stop_a(stop_a), .stop_b(stop_b),
      .slot_en(slot_en), .done_a(done_a), .done_b(done_b),
      .req_a(req_a), .req_b(req_b), .slot_a(slot_a), .slot_b(slot_b),
      .cmp_a(cmp_a), .cmp_b(cmp_b)
   );

   task automatic chk(input string tag, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   function automatic int pslot(input int p, input int lane);
      return (p / 4) * 8 + lane * 4 + (p % 4);
   endfunction

   task automatic idle(input int n);
      done_a = 0; done_b = 0;
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic pulse_a();
      start_a = 1; tick(); start_a = 0;
   endtask

   task automatic t_reset();
      chk("R1 req_a", req_a, 0);
      chk("R1 req_b", req_b, 0);
      chk("R1 cmp_a", cmp_a, 0);
      chk("R1 cmp_b", cmp_b, 0);
      chk("R1 slot_a", slot_a, 0);
      chk("R1 slot_b", slot_b, 4);
   endtask

   task automatic t_seq_full();
      mode_par = 0; slot_en = 16'hFFFF; done_a = 1;
      pulse_a();
      for (int i = 0; i < 16; i++) begin
         chk("R2 req_a", req_a, 1);
         chk("R2 slot_a", slot_a, i);
         chk("R2 req_b", req_b, 0);
         chk("R3 cmp_a early", cmp_a, 0);
         tick();
      end
      chk("R3 cmp_a after slot 15", cmp_a, 1);
      tick();
      chk("R3 cmp_a one cycle", cmp_a, 0);
      idle(2);
   endtask

   task automatic t_seq_gap();
      mode_par = 0; slot_en = 16'hFFDF; done_a = 1;
      pulse_a();
      for (int i = 0; i < 5; i++) begin
         chk("R3 slot_a", slot_a, i);
         tick();
      end
      chk("R3 no req on disabled", req_a, 0);
      chk("R3 slot_a at gap", slot_a, 5);
      chk("R3 cmp_a not yet", cmp_a, 0);
      tick();
      chk("R3 cmp_a at gap", cmp_a, 1);
      idle(2);
   endtask

   task automatic t_seq_slot0_off();
      mode_par = 0; slot_en = 16'hFFFE; done_a = 1;
      pulse_a();
      chk("R3 slot0 off no req", req_a, 0);
      tick();
      chk("R3 slot0 off cmp_a", cmp_a, 1);
      idle(2);
   endtask

   task automatic t_par_joint_full();
      mode_par = 1; simult = 1; slot_en = 16'hFFFF; done_a = 1; done_b = 1;
      pulse_a();
      for (int i = 0; i < 8; i++) begin
         chk("R4 req_a", req_a, 1);
         chk("R4 req_b", req_b, 1);
         chk("R4 slot_a", slot_a, pslot(i, 0));
         chk("R4 slot_b", slot_b, pslot(i, 1));
         tick();
      end
      chk("R5 cmp_a end", cmp_a, 1);
      chk("R5 cmp_b end", cmp_b, 1);
      idle(2);
   endtask

   task automatic t_par_joint_gap();
      mode_par = 1; simult = 1; slot_en = 16'hFFBF; done_a = 1; done_b = 1;
      pulse_a();
      tick(); tick();
      chk("R5 req_a still", req_a, 1);
      chk("R5 slot_a", slot_a, 2);
      chk("R5 req_b off", req_b, 0);
      chk("R5 slot_b", slot_b, 6);
      tick();
      chk("R5 cmp_a joint", cmp_a, 1);
      chk("R5 cmp_b joint", cmp_b, 1);
      chk("R5 req_a stopped", req_a, 0);
      idle(2);
   endtask

   task automatic t_par_indep();
      mode_par = 1; simult = 0; slot_en = 16'hFFFD; done_a = 1; done_b = 1;
      start_a = 1; start_b = 1; tick(); start_a = 0; start_b = 0;
      chk("R6 req_a", req_a, 1);
      chk("R6 req_b", req_b, 1);
      tick();
      chk("R6 req_a off at gap", req_a, 0);
      chk("R6 slot_b", slot_b, 5);
      tick();
      chk("R6 cmp_a alone", cmp_a, 1);
      chk("R6 cmp_b not yet", cmp_b, 0);
      for (int i = 2; i < 8; i++) begin
         chk("R6 slot_b run", slot_b, pslot(i, 1));
         chk("R6 req_b run", req_b, 1);
         tick();
      end
      chk("R6 cmp_b own end", cmp_b, 1);
      chk("R6 cmp_a quiet", cmp_a, 0);
      idle(2);
   endtask

   task automatic t_overlap_stop_combo();
      int cnt;
      mode_par = 0; slot_en = 16'hFFFF; done_a = 1; sync_en = 1;
      pulse_a();
      tick();
      sync_a = 1; tick(); sync_a = 0;
      chk("R7 sync during scan ignored", slot_a, 2);
      chk("R7 req_a kept", req_a, 1);
      stop_a = 1; tick();
      chk("R8 abort req_a", req_a, 0);
      chk("R8 abort no cmp", cmp_a, 0);
      start_a = 1; sync_a = 1; tick(); start_a = 0; sync_a = 0;
      chk("R8 trigger under stop", req_a, 0);
      stop_a = 0; tick();
      chk("R8 no pending launch", req_a, 0);
      chk("R8 no cmp after abort", cmp_a, 0);
      start_a = 1; sync_a = 1; tick(); start_a = 0; sync_a = 0;
      chk("R10 launch", req_a, 1);
      chk("R10 slot_a", slot_a, 0);
      cnt = 0;
      for (int i = 0; i < 40; i++) begin
         if (cmp_a) cnt++;
         tick();
      end
      chk("R10 single scan", cnt, 1);
      sync_en = 0; sync_a = 1; tick(); sync_a = 0;
      chk("R7 sync disabled", req_a, 0);
      idle(2);
   endtask

   task automatic t_stop_b();
      mode_par = 1; simult = 1; slot_en = 16'hFFFF; done_a = 1; done_b = 1;
      pulse_a();
      tick();
      stop_b = 1; tick();
      chk("R9 stop_b no effect joint", req_b, 1);
      chk("R9 slot_b joint", slot_b, 6);
      for (int i = 0; i < 6; i++) tick();
      chk("R9 joint cmp_b", cmp_b, 1);
      idle(2);
      simult = 0; done_a = 1; done_b = 1;
      start_a = 1; start_b = 1; tick(); start_a = 0; start_b = 0;
      chk("R9 start_b blocked", req_b, 0);
      chk("R9 a runs", req_a, 1);
      for (int i = 0; i < 8; i++) tick();
      chk("R9 cmp_a", cmp_a, 1);
      chk("R9 cmp_b none", cmp_b, 0);
      idle(2);
      stop_b = 0; done_a = 1; done_b = 1;
      start_a = 1; start_b = 1; tick(); start_a = 0; start_b = 0;
      tick();
      stop_b = 1; tick();
      chk("R9 b aborted", req_b, 0);
      chk("R9 a unaffected", slot_a, 2);
      chk("R9 a still req", req_a, 1);
      for (int i = 0; i < 6; i++) tick();
      chk("R9 cmp_a after abort b", cmp_a, 1);
      chk("R9 cmp_b after abort", cmp_b, 0);
      stop_b = 0;
      idle(2);
   endtask

   task automatic t_mask_capture();
      mode_par = 0; slot_en = 16'hFFFF; done_a = 1;
      pulse_a();
      slot_en = 16'h0000;
      tick(); tick();
      chk("R11 old mask kept", req_a, 1);
      chk("R11 slot_a", slot_a, 2);
      for (int i = 0; i < 14; i++) tick();
      chk("R11 full scan", cmp_a, 1);
      slot_en = 16'hFFFF;
      idle(2);
   endtask

   task automatic t_handshake();
      mode_par = 0; slot_en = 16'hFFFF; done_a = 0;
      pulse_a();
      tick();
      chk("R12 hold req", req_a, 1);
      chk("R12 hold slot", slot_a, 0);
      done_a = 1; tick(); done_a = 0;
      chk("R12 advance", slot_a, 1);
      tick();
      chk("R12 hold new slot", slot_a, 1);
      chk("R12 req still", req_a, 1);
      stop_a = 1; tick(); stop_a = 0;
      idle(2);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1;
      tick();
      t_reset();
      t_seq_full();
      t_seq_gap();
      t_seq_slot0_off();
      t_par_joint_full();
      t_par_joint_gap();
      t_par_indep();
      t_overlap_stop_combo();
      t_stop_b();
      t_mask_capture();
      t_handshake();
      if (!ended) begin
         ended = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         total++; bad++;
         $display("FAIL R12 watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule